// File: doc/BRIEF.md
# Prescaled Compare Timer/Counter

This block is an up-counter that takes a step only on prescaled ticks: a free-running phase counter divides the system clock by a parameter (eight by default) and gives a one-cycle tick. Between ticks the count holds. The counter runs either as a single byte or as a two-byte quantity. A width input selects the mode. In the byte mode only the low bytes of the counter and the compare values matter, and the counter's upper byte stays at zero.

Two compare values, A and B, each raise their own sticky flag. The flag sets on the tick that moves the counter off a value equal to that compare register. An overflow flag sets on the tick that wraps the counter from its all-ones value back to zero. In clear-on-compare mode, compare A acts as the top of the count: the tick that leaves the value A returns the counter to zero. The counter, both compare values and the flags sit behind a byte-wide register port. A single holding byte makes two-byte accesses atomic.

A write to the counter blocks compare matching for the next tick, so a value just written cannot raise a stale flag. A restart input puts the prescaler phase back to zero.

Top module: `ptc_timer`

## Requirements
- R1: After reset the counter, both compare values, the holding byte and all three flags read as zero.
- R2: The counter changes only on a prescaler tick, and the ticks come once every PSC_DIV clocks. After a prescaler restart, the first tick is on the PSC_DIV-th clock edge.
- R3: While `psc_restart` is high, no tick occurs and the phase returns to zero.
- R4: In byte mode (`cfg_wide`=0) and normal mode, a tick at count 0xFF takes the counter to 0x00 and sets the overflow flag (flag bit 0).
- R5: In wide mode (`cfg_wide`=1), a tick at count 0xFFFF takes the counter to 0x0000 and sets the overflow flag. Overflow sets in clear-on-compare mode too.
- R6: A tick taken while the counter equals compare A sets flag bit 1. A tick taken while it equals compare B sets flag bit 2. The counter still advances by one on that tick.
- R7: In clear-on-compare mode (`cfg_ctc`=1), a tick taken while the counter equals compare A returns it to zero, and flag bit 1 sets on that same tick.
- R8: In byte mode, compares use only the low byte, and a write to a low address loads zero into the upper byte. The counter's upper byte stays zero.
- R9: Register map, with byte addresses: 0 counter low, 1 counter high, 2 compare A low, 3 compare A high, 4 compare B low, 5 compare B high, 6 flags (bit 0 overflow, 1 match A, 2 match B), 7 reads zero. A write to an odd address 1, 3 or 5 loads the holding byte. A write to a low address in wide mode loads {holding byte, data} in one cycle. A read of a low address in wide mode copies that register's high byte into the holding byte. Reads of the odd addresses return the holding byte.
- R10: Flags stay set until a write to address 6 with a one in their bit. A flag set on the same cycle as its clear stays set.
- R11: A write to the counter suppresses the compare A and B flags and the clear-on-compare reset on the next tick. A write cycle that coincides with a tick loads the written value instead of counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psc_restart | input | 1 | Restarts the prescaler phase at zero |
| cfg_wide | input | 1 | 1: two-byte counter and compares; 0: one byte |
| cfg_ctc | input | 1 | 1: clear on compare A; 0: free-running wrap |
| bus_addr | input | 3 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (drives the holding-byte capture) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq_flags | output | 3 | Sticky flags: bit 0 overflow, bit 1 match A, bit 2 match B |

## Verification
The assertions check the following on every cycle: the count holds between ticks, a restart swallows the tick, overflow wraps to zero and sets its flag, a clear-on-compare match returns the counter to zero, the upper byte stays zero in byte mode, flags remain sticky, and matching is blocked after a counter write. Some behaviour only the bench's scenarios can show, because it needs a known starting phase and a chosen register history. This covers the exact clock on which a tick lands after a restart, the order of the holding-byte capture and the two-byte commit, a flag that survives a clear written on its setting tick, and the counting through 0xFFFF.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

    typedef enum logic [2:0] {
        A_CNT_LO = 3'd0,
        A_CNT_HI = 3'd1,
        A_CPA_LO = 3'd2,
        A_CPA_HI = 3'd3,
        A_CPB_LO = 3'd4,
        A_CPB_HI = 3'd5,
        A_FLAGS  = 3'd6,
        A_RSVD   = 3'd7
    } reg_addr_e;

    localparam int N_FLAGS = 3;
    localparam int F_OVF   = 0;
    localparam int F_CPA   = 1;
    localparam int F_CPB   = 2;

endpackage

// File: rtl/ptc_prescaler.sv
module ptc_prescaler #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] ph_d, ph_q;

    always_comb begin
        if (restart || ph_q == LAST) begin
            ph_d = '0;
        end else begin
            ph_d = ph_q + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_d;
        end
    end

    // R3: a restart cycle never ticks
    assign tick = !restart && (ph_q == LAST);

endmodule

// File: rtl/ptc_match.sv
module ptc_match #(
    parameter int W = 16
) (
    input  logic [W-1:0] value,
    input  logic [W-1:0] ref_val,
    input  logic [W-1:0] mask,
    output logic         hit
);
    assign hit = ((value ^ ref_val) & mask) == '0;
endmodule

// File: rtl/ptc_timer.sv
module ptc_timer import ptc_pkg::*; #(
    parameter int DATA_W  = 8,
    parameter int PSC_DIV = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psc_restart,
    input  logic              cfg_wide,
    input  logic              cfg_ctc,
    input  logic [2:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [N_FLAGS-1:0] irq_flags
);
    localparam int CNT_W = 2 * DATA_W;
    localparam int N_CMP = 2;

    typedef struct packed {
        logic [CNT_W-1:0]   cnt;
        logic [CNT_W-1:0]   cmp_a;
        logic [CNT_W-1:0]   cmp_b;
        logic [DATA_W-1:0]  tmp;
        logic [N_FLAGS-1:0] flg;
        logic               blk;
    } state_t;

    state_t             st_d, st_q;
    reg_addr_e          addr;
    logic               tick, cnt_wr, at_max;
    logic [CNT_W-1:0]   cnt_mask, joined;
    logic [CNT_W-1:0]   cmp_val [N_CMP];
    logic [N_CMP-1:0]   cmp_eq;
    logic [N_FLAGS-1:0] flg_set, flg_clr;
    logic [CNT_W-1:0]   cnt_now;
    logic               blk_now, eq_a;

    assign addr     = reg_addr_e'(bus_addr);
    assign cnt_mask = cfg_wide ? {CNT_W{1'b1}} : {{DATA_W{1'b0}}, {DATA_W{1'b1}}};
    // R9: two-byte commit from the holding byte; R8: zero upper byte in byte mode
    assign joined   = cfg_wide ? {st_q.tmp, bus_wdata} : {{DATA_W{1'b0}}, bus_wdata};
    assign cnt_wr   = bus_wr && (addr == A_CNT_LO);
    assign cmp_val[0] = st_q.cmp_a;
    assign cmp_val[1] = st_q.cmp_b;

    ptc_prescaler #(.DIV(PSC_DIV)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (psc_restart),
        .tick    (tick)
    );

    generate
        for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
            ptc_match #(.W(CNT_W)) u_eq (
                .value   (st_q.cnt),
                .ref_val (cmp_val[g]),
                .mask    (cnt_mask),
                .hit     (cmp_eq[g])
            );
        end
    endgenerate

    ptc_match #(.W(CNT_W)) u_top (
        .value   (st_q.cnt),
        .ref_val (cnt_mask),
        .mask    (cnt_mask),
        .hit     (at_max)
    );

    always_comb begin
        st_d    = st_q;
        flg_set = '0;
        flg_clr = (bus_wr && addr == A_FLAGS) ? bus_wdata[N_FLAGS-1:0] : '0;

        if (cnt_wr) begin
            // R11: a written value arms the one-tick match block
            st_d.cnt = joined;
            st_d.blk = 1'b1;
        end else if (tick) begin
            flg_set[F_OVF] = at_max;
            flg_set[F_CPA] = !st_q.blk && cmp_eq[0];
            flg_set[F_CPB] = !st_q.blk && cmp_eq[1];
            st_d.blk       = 1'b0;
            if ((cfg_ctc && flg_set[F_CPA]) || at_max) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = (st_q.cnt + CNT_W'(1)) & cnt_mask;
            end
        end

        if (bus_wr && addr == A_CPA_LO) st_d.cmp_a = joined;
        if (bus_wr && addr == A_CPB_LO) st_d.cmp_b = joined;

        if (bus_wr && (addr == A_CNT_HI || addr == A_CPA_HI || addr == A_CPB_HI)) begin
            st_d.tmp = bus_wdata;
        end else if (bus_rd && cfg_wide) begin
            case (addr)
                A_CNT_LO: st_d.tmp = st_q.cnt[CNT_W-1:DATA_W];
                A_CPA_LO: st_d.tmp = st_q.cmp_a[CNT_W-1:DATA_W];
                A_CPB_LO: st_d.tmp = st_q.cmp_b[CNT_W-1:DATA_W];
                default:  st_d.tmp = st_q.tmp;
            endcase
        end

        // R10: hardware set wins over a simultaneous clear
        st_d.flg = (st_q.flg & ~flg_clr) | flg_set;
    end

    always_comb begin
        case (addr)
            A_CNT_LO: bus_rdata = st_q.cnt[DATA_W-1:0];
            A_CPA_LO: bus_rdata = st_q.cmp_a[DATA_W-1:0];
            A_CPB_LO: bus_rdata = st_q.cmp_b[DATA_W-1:0];
            A_CNT_HI,
            A_CPA_HI,
            A_CPB_HI: bus_rdata = st_q.tmp;
            A_FLAGS:  bus_rdata = DATA_W'(st_q.flg);
            default:  bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_flags = st_q.flg;
    assign cnt_now   = st_q.cnt;
    assign blk_now   = st_q.blk;
    assign eq_a      = cmp_eq[0];

endmodule

// File: rtl/ptc_checker.sv
module ptc_checker import ptc_pkg::*; #(
    parameter int DATA_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tick,
    input logic                cnt_wr,
    input logic                blk,
    input logic                at_max,
    input logic                eq_a,
    input logic [2*DATA_W-1:0] cnt,
    input logic                cfg_wide,
    input logic                cfg_ctc,
    input logic                psc_restart,
    input logic                bus_wr,
    input logic [2:0]          bus_addr,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic [N_FLAGS-1:0]  flags
);
    localparam int CW = 2 * DATA_W;

    logic clr_a;
    assign clr_a = bus_wr && (bus_addr == A_FLAGS) && bus_wdata[F_CPA];

    a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr) |=> $stable(cnt));

    a_r3_restart_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        psc_restart |=> !tick);

    a_r4_overflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && at_max) |=> flags[F_OVF]);

    a_r5_wide_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && at_max && cfg_wide) |=> (cnt == '0));

    a_r7_ctc_bottom: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && !blk && cfg_ctc && eq_a) |=> (cnt == '0 && flags[F_CPA]));

    a_r8_narrow_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wide && cnt[CW-1:DATA_W] == '0) |=> (cnt[CW-1:DATA_W] == '0));

    a_r10_sticky_a: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[F_CPA] && !clr_a) |=> flags[F_CPA]);

    a_r11_block_match: assert property (@(posedge clk) disable iff (!rst_n)
        (blk && tick && !cnt_wr && !flags[F_CPA]) |=> !flags[F_CPA]);

endmodule

bind ptc_timer ptc_checker #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .cnt_wr      (cnt_wr),
    .blk         (blk_now),
    .at_max      (at_max),
    .eq_a        (eq_a),
    .cnt         (cnt_now),
    .cfg_wide    (cfg_wide),
    .cfg_ctc     (cfg_ctc),
    .psc_restart (psc_restart),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .flags       (irq_flags)
);

// File: tb/tb_ptc_timer.sv
`timescale 1ns/1ps
module tb_ptc_timer;
    localparam int DIV = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       psc_restart = 1'b0;
    logic       cfg_wide = 1'b0;
    logic       cfg_ctc = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic [2:0] irq_flags;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // reference model state
    int m_cnt = 0, m_a = 0, m_b = 0, m_tmp = 0, m_psc = 0;
    bit m_ovf = 0, m_fa = 0, m_fb = 0, m_blk = 0;

    ptc_timer #(.DATA_W(8), .PSC_DIV(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .psc_restart(psc_restart),
        .cfg_wide(cfg_wide), .cfg_ctc(cfg_ctc),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_flags(irq_flags)
    );

    always #4 clk = ~clk;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int m_mask();
        return cfg_wide ? 32'hFFFF : 32'h00FF;
    endfunction

    function automatic int m_rdata();
        case (bus_addr)
            3'd0: return m_cnt & 255;
            3'd2: return m_a & 255;
            3'd4: return m_b & 255;
            3'd1, 3'd3, 3'd5: return m_tmp;
            3'd6: return (int'(m_fb) << 2) | (int'(m_fa) << 1) | int'(m_ovf);
            default: return 0;
        endcase
    endfunction

    task automatic m_update();
        int msk = m_mask();
        int o_cnt = m_cnt, o_a = m_a, o_b = m_b, o_tmp = m_tmp;
        int wd = int'(bus_wdata);
        int ad = int'(bus_addr);
        bit tk = !psc_restart && (m_psc == DIV - 1);
        bit so = 0, sa = 0, sb = 0;
        int clr = (bus_wr && ad == 6) ? wd : 0;
        m_psc = (psc_restart || m_psc == DIV - 1) ? 0 : m_psc + 1;
        if (bus_wr && ad == 0) begin
            m_cnt = cfg_wide ? ((o_tmp << 8) | wd) : wd;
            m_blk = 1;
        end else if (tk) begin
            so = ((o_cnt & msk) == msk);
            sa = !m_blk && (((o_cnt ^ o_a) & msk) == 0);
            sb = !m_blk && (((o_cnt ^ o_b) & msk) == 0);
            m_blk = 0;
            if ((cfg_ctc && sa) || so) m_cnt = 0;
            else m_cnt = (o_cnt + 1) & msk;
        end
        if (bus_wr && ad == 2) m_a = cfg_wide ? ((o_tmp << 8) | wd) : wd;
        if (bus_wr && ad == 4) m_b = cfg_wide ? ((o_tmp << 8) | wd) : wd;
        if (bus_wr && (ad == 1 || ad == 3 || ad == 5)) m_tmp = wd;
        else if (bus_rd && cfg_wide) begin
            if (ad == 0) m_tmp = (o_cnt >> 8) & 255;
            else if (ad == 2) m_tmp = (o_a >> 8) & 255;
            else if (ad == 4) m_tmp = (o_b >> 8) & 255;
        end
        m_ovf = (m_ovf && !clr[0]) || so;
        m_fa  = (m_fa  && !clr[1]) || sa;
        m_fb  = (m_fb  && !clr[2]) || sb;
    endtask

    // one clock: drive, compare to model, optional constant check, advance
    task automatic step(bit wr, bit rd, int ad, int wd, bit prst, int exp = -1, string tag = "");
        bus_wr = wr; bus_rd = rd; bus_addr = 3'(ad); bus_wdata = 8'(wd); psc_restart = prst;
        #1;
        chk("model rdata R9", int'(bus_rdata), m_rdata());
        chk("model flags R10", int'(irq_flags), (int'(m_fb) << 2) | (int'(m_fa) << 1) | int'(m_ovf));
        if (exp >= 0) chk(tag, int'(bus_rdata), exp);
        @(posedge clk);
        m_update();
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 1, 0, 0, 0);
    endtask

    task automatic wr(int ad, int wd, bit prst = 0);
        step(1, 0, ad, wd, prst);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        step(0, 1, 0, 0, 0, 0, "R1 counter");
        step(0, 1, 2, 0, 0, 0, "R1 compare A");
        step(0, 1, 4, 0, 0, 0, "R1 compare B");
        step(0, 1, 1, 0, 0, 0, "R1 holding byte");
        step(0, 1, 6, 0, 0, 0, "R1 flags");

        // R2/R3: tick spacing and restart
        wr(0, 8'h10, 1);
        idle(7);
        step(0, 1, 0, 0, 0, 8'h10, "R2 before tick");
        step(0, 1, 0, 0, 0, 8'h11, "R2 after tick");
        idle(4);
        step(0, 1, 0, 0, 1);
        idle(7);
        step(0, 1, 0, 0, 0, 8'h11, "R3 restart delays tick");
        step(0, 1, 0, 0, 0, 8'h12, "R3 tick after restart");

        // R4: byte-mode overflow
        wr(6, 7);
        wr(0, 8'hFE, 1);
        idle(24);
        #1;
        chk("R4 overflow flag", int'(irq_flags[0]), 1);
        step(0, 1, 0, 0, 0, 8'h01, "R4 counter wrapped");

        // R6: compare flags
        wr(2, 8'h20);
        wr(4, 8'h18);
        wr(6, 7);
        wr(0, 8'h17, 1);
        idle(16);
        #1;
        chk("R6 match B only", int'(irq_flags), 3'b100);
        idle(64);
        #1;
        chk("R6 match A added", int'(irq_flags), 3'b110);

        // R7: clear on compare A
        cfg_ctc = 1'b1;
        wr(2, 8'h05);
        wr(6, 7);
        wr(0, 8'h03, 1);
        idle(16);
        step(0, 1, 0, 0, 0, 8'h05, "R7 at top");
        idle(7);
        step(0, 1, 0, 0, 0, 8'h00, "R7 back to bottom");
        #1;
        chk("R7 flag A", int'(irq_flags[1]), 1);
        cfg_ctc = 1'b0;

        // R11: write blocks the next match
        wr(2, 8'h40);
        wr(6, 7);
        wr(0, 8'h40, 1);
        idle(8);
        #1;
        chk("R11 match blocked", int'(irq_flags[1]), 0);
        wr(0, 8'h3F, 1);
        idle(16);
        #1;
        chk("R11 match after unblock", int'(irq_flags[1]), 1);

        // R10: set wins over clear in the same cycle
        wr(2, 8'h60);
        wr(6, 7);
        wr(0, 8'h5F, 1);
        idle(15);
        wr(6, 2);
        #1;
        chk("R10 set beats clear", int'(irq_flags[1]), 1);
        wr(6, 2);
        #1;
        chk("R10 write-one clear", int'(irq_flags[1]), 0);

        // R8: byte mode uses low byte only
        cfg_wide = 1'b1;
        wr(5, 8'h12);
        wr(4, 8'h50);
        cfg_wide = 1'b0;
        wr(6, 7);
        wr(0, 8'h4F, 1);
        idle(16);
        #1;
        chk("R8 low-byte compare", int'(irq_flags[2]), 1);
        cfg_wide = 1'b1;
        step(0, 1, 0, 0, 0);
        step(0, 1, 1, 0, 0, 0, "R8 upper byte zero");

        // R9/R5: two-byte access and wide overflow
        wr(1, 8'hFF);
        wr(0, 8'hFD, 1);
        wr(6, 7);
        step(0, 1, 0, 0, 0, 8'hFD, "R9 low byte");
        step(0, 1, 1, 0, 0, 8'hFF, "R9 captured high byte");
        wr(1, 8'h00);
        step(0, 1, 1, 0, 0, 8'h00, "R9 holding byte write");
        idle(32);
        #1;
        chk("R5 wide overflow flag", int'(irq_flags[0]), 1);
        step(0, 1, 0, 0, 0, 8'h01, "R5 wide wrap low");
        step(0, 1, 1, 0, 0, 8'h00, "R5 wide wrap high");

        // mixed traffic against the model
        for (int i = 0; i < 6000; i++) begin
            int r = $urandom_range(0, 99);
            if (i % 700 == 0) begin
                cfg_wide = 1'($urandom_range(0, 1));
                cfg_ctc  = 1'($urandom_range(0, 1));
            end
            if (r < 4) wr(0, ($urandom_range(0, 3) == 0) ? 8'hFF : $urandom_range(0, 255));
            else if (r < 8) wr($urandom_range(1, 6), $urandom_range(0, 255));
            else if (r < 10) wr(2, $urandom_range(0, 31));
            else if (r < 20) step(0, 1, $urandom_range(0, 7), 0, 0);
            else if (r < 22) step(0, 1, 0, 0, 1);
            else step(0, 1, 0, 0, 0);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule